// File: doc/BRIEF.md
# SIMD Lane Extract Execution Unit

This unit picks one 32-bit lane out of a 128-bit vector register value and hands it to a scalar destination. The lane index comes from the low bits of an 8-bit immediate. The lane's bits are moved unchanged, and no floating-point meaning is given to them. The unit also checks the encoding fields of the instruction. A VEX-style or EVEX-style instruction whose register-specifier field is not all ones raises an undefined-opcode fault. A VEX-style instruction with its length bit set also raises that fault. The legacy form has neither field, so it is never checked.

Each issued operation gives its result one clock edge later, on registered outputs. A register destination receives the lane zero-extended to 64 bits. A memory destination receives the 32-bit lane on a separate store-data path. The W bit is accepted on the port but never changes the outcome. Decode of the prefix bytes, operand addressing and the memory access itself are handled elsewhere.

Top module: `lane_extract_unit`

## Requirements
- R1: The selected lane is bits [32*k+31 : 32*k] of the source, where k = imm[1:0]. The bits are copied exactly, including NaN and denormal patterns.
- R2: Immediate bits [7:2] have no effect on any output and never raise the fault.
- R3: For a legal register-destination operation, res_o[31:0] holds the lane and res_o[63:32] is zero. This holds in both 64-bit mode and the other mode. st_data_o is zero.
- R4: The W bit has no effect on any output.
- R5: The form field is encoded as 0 = legacy, 1 = VEX, 2 = EVEX and 3 = reserved, which is checked like EVEX. For any form other than 0, a vvvv field other than 4'b1111 raises ud_o.
- R6: Form 1 with len_i = 1 raises ud_o. len_i is not checked for forms 2 and 3. Form 0 never raises ud_o, whatever its vvvv and length fields hold.
- R7: For a legal memory-destination operation, st_data_o holds the lane and res_o is zero.
- R8: When ud_o is high, wr_en_o is low and both res_o and st_data_o are zero.
- R9: Outputs are registered, so an operation issued at edge n appears after edge n. In a cycle that follows no issue, and after reset, wr_en_o, ud_o, res_o and st_data_o are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_i | input | 1 | Operation is presented this cycle |
| src_i | input | 128 | Vector source value |
| imm_i | input | 8 | Immediate; the low 2 bits select the lane |
| form_i | input | 2 | Encoding form: 0 legacy, 1 VEX, 2 EVEX, 3 reserved |
| len_i | input | 1 | Vector length bit of the encoding |
| vvvv_i | input | 4 | Register-specifier field, which must be 4'b1111 |
| mode64_i | input | 1 | 64-bit mode flag |
| dst_reg_i | input | 1 | 1 = register destination, 0 = memory destination |
| w_i | input | 1 | W bit (ignored) |
| res_o | output | 64 | Register-destination result |
| st_data_o | output | 32 | Memory-destination store data |
| wr_en_o | output | 1 | Result commit strobe |
| ud_o | output | 1 | Undefined-opcode fault |

## Verification
The legality trap and the lane write are worked out in the same cycle from the same operation. A fault must therefore suppress a lane that would otherwise be valid. The sweep provokes this by pairing every immediate, form, mode, destination and W value with a vvvv field that is all ones half the time and a random length bit. Every illegal combination thus arrives together with a real source value. For each such cycle, the bench checks that wr_en_o is low and that both data paths are zero. For each legal cycle, it checks that the lane lands on exactly one of the two data paths.

// File: rtl/lxu_pkg.sv
package lxu_pkg;
  typedef enum logic [1:0] {
    FORM_LEGACY = 2'd0,
    FORM_VEX    = 2'd1,
    FORM_EVEX   = 2'd2,
    FORM_RSVD   = 2'd3
  } form_e;

  localparam logic [3:0] VVVV_UNUSED = 4'b1111;
endpackage

// File: rtl/lxu_lane_sel.sv
module lxu_lane_sel #(
  parameter int VEC_W  = 128,
  parameter int LANE_W = 32,
  parameter int IMM_W  = 8,
  localparam int LANES = VEC_W / LANE_W,
  localparam int IDX_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic [VEC_W-1:0]  src,
  input  logic [IMM_W-1:0]  imm,
  output logic [LANE_W-1:0] lane
);
  logic [LANE_W-1:0] lanes [LANES];
  logic [IDX_W-1:0]  idx;

  for (genvar g = 0; g < LANES; g++) begin : g_split
    assign lanes[g] = src[g*LANE_W +: LANE_W];
  end

  // only the low index bits are used; the rest of the immediate is dropped
  assign idx  = imm[IDX_W-1:0];
  assign lane = lanes[idx];
endmodule

// File: rtl/lxu_legality.sv
module lxu_legality
  import lxu_pkg::*;
(
  input  logic [1:0] form,
  input  logic       len,
  input  logic [3:0] vvvv,
  output logic       fault
);
  form_e f;
  logic  bad_vvvv;
  logic  bad_len;

  always_comb begin
    f        = form_e'(form);
    bad_vvvv = (f != FORM_LEGACY) && (vvvv != VVVV_UNUSED);
    bad_len  = (f == FORM_VEX) && len;
    fault    = bad_vvvv || bad_len;
  end
endmodule

// File: rtl/lane_extract_unit.sv
module lane_extract_unit #(
  parameter int VEC_W  = 128,
  parameter int LANE_W = 32,
  parameter int IMM_W  = 8,
  parameter int RES_W  = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              issue_i,
  input  logic [VEC_W-1:0]  src_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic [1:0]        form_i,
  input  logic              len_i,
  input  logic [3:0]        vvvv_i,
  input  logic              mode64_i,
  input  logic              dst_reg_i,
  input  logic              w_i,
  output logic [RES_W-1:0]  res_o,
  output logic [LANE_W-1:0] st_data_o,
  output logic              wr_en_o,
  output logic              ud_o
);
  localparam int PAD_W = RES_W - LANE_W;

  logic [LANE_W-1:0] lane;
  logic              fault;
  logic              ok;
  logic [RES_W-1:0]  res_d;
  logic [LANE_W-1:0] st_d;
  logic              ignored;

  lxu_lane_sel #(
    .VEC_W (VEC_W),
    .LANE_W(LANE_W),
    .IMM_W (IMM_W)
  ) u_sel (
    .src (src_i),
    .imm (imm_i),
    .lane(lane)
  );

  lxu_legality u_leg (
    .form (form_i),
    .len  (len_i),
    .vvvv (vvvv_i),
    .fault(fault)
  );

  // W and the mode flag never alter the data: the upper half is zero either way
  assign ignored = w_i ^ mode64_i;

  always_comb begin
    ok    = issue_i && !fault;
    res_d = '0;
    st_d  = '0;
    if (ok && dst_reg_i)  res_d = {{PAD_W{1'b0}}, lane};
    if (ok && !dst_reg_i) st_d  = lane;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_o     <= '0;
      st_data_o <= '0;
      wr_en_o   <= 1'b0;
      ud_o      <= 1'b0;
    end else begin
      res_o     <= res_d;
      st_data_o <= st_d;
      wr_en_o   <= ok;
      ud_o      <= issue_i && fault;
    end
  end

  logic unused_ok;
  assign unused_ok = ignored;
endmodule

// File: rtl/lxu_checker.sv
module lxu_checker #(
  parameter int LANE_W = 32,
  parameter int RES_W  = 64
) (
  input logic              clk,
  input logic              rst,
  input logic              issue_i,
  input logic [1:0]        form_i,
  input logic              len_i,
  input logic [3:0]        vvvv_i,
  input logic [RES_W-1:0]  res_o,
  input logic [LANE_W-1:0] st_data_o,
  input logic              wr_en_o,
  input logic              ud_o
);
  p_fault_blocks_write_r8: assert property (@(posedge clk) disable iff (rst)
    ud_o |-> (!wr_en_o && res_o == '0 && st_data_o == '0));

  p_upper_zero_r3: assert property (@(posedge clk) disable iff (rst)
    res_o[RES_W-1:LANE_W] == '0);

  p_vvvv_trap_r5: assert property (@(posedge clk) disable iff (rst)
    (issue_i && form_i != 2'd0 && vvvv_i != 4'hF) |=> ud_o);

  p_vex_len_trap_r6: assert property (@(posedge clk) disable iff (rst)
    (issue_i && form_i == 2'd1 && len_i) |=> ud_o);

  p_legacy_no_trap_r6: assert property (@(posedge clk) disable iff (rst)
    (issue_i && form_i == 2'd0) |=> !ud_o);

  p_one_path_r7: assert property (@(posedge clk) disable iff (rst)
    (st_data_o != '0) |-> (res_o == '0 && wr_en_o));

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    !issue_i |=> (!wr_en_o && !ud_o && res_o == '0 && st_data_o == '0));
endmodule

bind lane_extract_unit lxu_checker #(
  .LANE_W(LANE_W),
  .RES_W (RES_W)
) u_lxu_chk (
  .clk      (clk),
  .rst      (rst),
  .issue_i  (issue_i),
  .form_i   (form_i),
  .len_i    (len_i),
  .vvvv_i   (vvvv_i),
  .res_o    (res_o),
  .st_data_o(st_data_o),
  .wr_en_o  (wr_en_o),
  .ud_o     (ud_o)
);

// File: tb/tb_lane_extract_unit.sv
`timescale 1ns/1ps
module tb_lane_extract_unit;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         issue_i = 1'b0;
  logic [127:0] src_i = '0;
  logic [7:0]   imm_i = '0;
  logic [1:0]   form_i = '0;
  logic         len_i = 1'b0;
  logic [3:0]   vvvv_i = 4'hF;
  logic         mode64_i = 1'b0;
  logic         dst_reg_i = 1'b0;
  logic         w_i = 1'b0;
  logic [63:0]  res_o;
  logic [31:0]  st_data_o;
  logic         wr_en_o;
  logic         ud_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  lane_extract_unit dut (
    .clk(clk), .rst(rst), .issue_i(issue_i), .src_i(src_i), .imm_i(imm_i),
    .form_i(form_i), .len_i(len_i), .vvvv_i(vvvv_i), .mode64_i(mode64_i),
    .dst_reg_i(dst_reg_i), .w_i(w_i), .res_o(res_o), .st_data_o(st_data_o),
    .wr_en_o(wr_en_o), .ud_o(ud_o)
  );

  function automatic logic [31:0] exp_lane(logic [127:0] s, logic [7:0] im);
    return s[im[1:0]*32 +: 32];
  endfunction

  function automatic logic exp_fault(logic [1:0] f, logic l, logic [3:0] v);
    return (f != 2'd0 && v != 4'hF) || (f == 2'd1 && l);
  endfunction

  task automatic check(string req, logic [63:0] er, logic [31:0] es, logic ew, logic eu);
    checks++;
    if (res_o !== er || st_data_o !== es || wr_en_o !== ew || ud_o !== eu) begin
      failures++;
      $display("FAIL %s: res=%h st=%h we=%b ud=%b expected res=%h st=%h we=%b ud=%b",
               req, res_o, st_data_o, wr_en_o, ud_o, er, es, ew, eu);
    end
  endtask

  // drive at a falling edge, result visible after the next rising edge
  task automatic run_op(string req, logic [127:0] s, logic [7:0] im, logic [1:0] f,
                        logic l, logic [3:0] v, logic m, logic d, logic w);
    logic fl;
    logic [31:0] ln;
    issue_i = 1'b1; src_i = s; imm_i = im; form_i = f; len_i = l;
    vvvv_i = v; mode64_i = m; dst_reg_i = d; w_i = w;
    @(negedge clk);
    fl = exp_fault(f, l, v);
    ln = exp_lane(s, im);
    if (fl)      check(req, 64'd0, 32'd0, 1'b0, 1'b1);
    else if (d)  check(req, {32'd0, ln}, 32'd0, 1'b1, 1'b0);
    else         check(req, 64'd0, ln, 1'b1, 1'b0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [127:0] s;
    logic [63:0] r0;
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    check("R9 reset", 64'd0, 32'd0, 1'b0, 1'b0);
    rst = 1'b0;

    // R1 exact bit copy for every lane, with NaN / denormal patterns
    s = {32'h7FC0_0001, 32'h0000_0001, 32'hFF80_0000, 32'h807F_FFFF};
    for (int k = 0; k < 4; k++) run_op("R1 lane copy", s, 8'(k), 2'd0, 1'b0, 4'h0, 1'b1, 1'b1, 1'b0);

    // R2 upper immediate bits ignored, including on VEX form
    run_op("R2 imm high bits", s, 8'hFE, 2'd1, 1'b0, 4'hF, 1'b1, 1'b1, 1'b0);
    r0 = res_o;
    run_op("R2 imm high bits", s, 8'h02, 2'd1, 1'b0, 4'hF, 1'b1, 1'b1, 1'b0);
    checks++;
    if (res_o !== r0) begin failures++; $display("FAIL R2: res=%h expected %h", res_o, r0); end

    // R4 W bit has no effect
    run_op("R4 w=1", s, 8'h03, 2'd2, 1'b1, 4'hF, 1'b1, 1'b1, 1'b1);
    r0 = res_o;
    run_op("R4 w=0", s, 8'h03, 2'd2, 1'b1, 4'hF, 1'b1, 1'b1, 1'b0);
    checks++;
    if (res_o !== r0) begin failures++; $display("FAIL R4: res=%h expected %h", res_o, r0); end

    // R5 / R6 / R8 directed traps
    run_op("R5 vvvv trap evex", s, 8'h01, 2'd2, 1'b0, 4'hE, 1'b1, 1'b1, 1'b0);
    run_op("R5 vvvv trap rsvd", s, 8'h01, 2'd3, 1'b0, 4'h7, 1'b0, 1'b0, 1'b0);
    run_op("R6 vex len trap", s, 8'h01, 2'd1, 1'b1, 4'hF, 1'b1, 1'b0, 1'b0);
    run_op("R6 legacy unchecked", s, 8'h01, 2'd0, 1'b1, 4'h3, 1'b1, 1'b0, 1'b0);
    run_op("R8 fault then memory", s, 8'h00, 2'd1, 1'b1, 4'h0, 1'b0, 1'b0, 1'b1);

    // R9 idle cycle after traffic
    issue_i = 1'b0;
    @(negedge clk);
    check("R9 idle", 64'd0, 32'd0, 1'b0, 1'b0);

    // sweep: every immediate, form, W, mode, destination
    for (int im = 0; im < 256; im++)
      for (int f = 0; f < 4; f++)
        for (int w = 0; w < 2; w++)
          for (int m = 0; m < 2; m++)
            for (int d = 0; d < 2; d++) begin
              logic [3:0] v;
              logic l;
              s = {$urandom, $urandom, $urandom, $urandom};
              v = ($urandom % 2) ? 4'hF : 4'($urandom);
              l = 1'($urandom);
              run_op(exp_fault(2'(f), l, v) ? "R5/R8 sweep trap" :
                     (d != 0) ? "R3 sweep reg" : "R7 sweep mem",
                     s, 8'(im), 2'(f), l, v, 1'(m), 1'(d), 1'(w));
            end

    issue_i = 1'b0;
    @(negedge clk);
    check("R9 idle end", 64'd0, 32'd0, 1'b0, 1'b0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule